// File: doc/BRIEF.md
# Frame Buffer Burst Scheduler

This block sits between a video writer FIFO, a display reader FIFO and a single-ported frame memory, all in one clock domain. It watches the occupancy of the write FIFO and the free space of the read FIFO. It picks one fixed-length burst at a time, either moving words from the write FIFO into memory or moving words from memory into the read FIFO. It also produces the burst-aligned word address for each transfer. The memory side is an abstract burst port: a one-cycle command strobe with a direction and an address, write data beats, and read data beats returned by the memory. Command sequencing, refresh and device timing of the memory are handled below this port.

The controller is a three-state machine. `ST_IDLE` makes the arbitration decision. `ST_WRITE` and `ST_READ` each last exactly `BURST_CYC` cycles. The transitions are: IDLE to WRITE when a write is granted; IDLE to READ when a read is granted; IDLE to IDLE when nothing is eligible; and WRITE or READ back to IDLE on the final beat. Display reads are held off until one full field of write bursts has been stored. After that point the read gate stays open until reset. The write and read burst pointers walk through the frame region on their own and wrap at its end.

Top module: `fb_burst_sched`

## Requirements
- R1: Every transfer holds its state for exactly `BURST_CYC` (8) cycles. `mem_cmd` is high only in the first of these cycles. A new command can appear no earlier than one idle cycle after the previous burst ends. During a write burst, `wf_pop` and `mem_wvalid` are high in the first `BURST_LEN` (4) cycles and low in the rest.
- R2: A write burst starts only if `wf_level` was at least `BURST_LEN` in the idle cycle where the decision was made.
- R3: A read burst starts only if, in the idle decision cycle, `rf_free` was at least `BURST_LEN` and `rd_enabled` was high.
- R4: `rd_enabled` is low after reset. It goes high in the cycle after the last cycle of the `FIELD_BURSTS`-th completed write burst.
- R5: Once `rd_enabled` is high, it stays high until reset.
- R6: If a write and a read are both eligible in the idle cycle, the grant goes opposite to the direction of the previous burst. After reset, the previous direction counts as read, so the first contested grant goes to the write. If only one is eligible, that one starts. If neither is eligible, the block stays idle.
- R7: `mem_addr` equals the burst index times `BURST_LEN`. The n-th write burst (counted from 0) uses index n mod `FRAME_BURSTS`. Reads keep their own independent index in the same way.
- R8: Write beats carry `wf_data` unchanged, in pop order, on `mem_wdata`. During a read burst, `rf_push` follows `mem_rvalid` and `rf_data` equals `mem_rdata`. Outside a read burst, `rf_push` is low.
- R9: During and straight after reset, `mem_cmd`, `wf_pop`, `rf_push` and `rd_enabled` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Encoder-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wf_level | input | LVL_W | Words held in the write FIFO |
| wf_data | input | DATA_W | Head word of the write FIFO |
| wf_pop | output | 1 | Removes the head word of the write FIFO |
| rf_free | input | LVL_W | Free word slots in the read FIFO |
| rf_push | output | 1 | Writes `rf_data` into the read FIFO |
| rf_data | output | DATA_W | Word forwarded to the read FIFO |
| mem_cmd | output | 1 | One-cycle burst start strobe |
| mem_we | output | 1 | Burst direction, 1 = write |
| mem_addr | output | ADDR_W | Burst start word address |
| mem_wdata | output | DATA_W | Write beat data |
| mem_wvalid | output | 1 | Write beat valid |
| mem_rdata | input | DATA_W | Read beat data from memory |
| mem_rvalid | input | 1 | Read beat valid from memory |
| rd_enabled | output | 1 | Display read gate is open |

## Verification
If the beat counter is corrupted, it shows in the burst after the fault. The command spacing changes, or the pop pattern changes, and both are visible. If a pointer fault occurs, `mem_addr` is wrong at the next burst start in that direction. It also shows up later as read data that does not match what was written at that address. If the arbitration memory flips, the next contested idle cycle starts the wrong direction, and the bench predicts every such cycle from the inputs it drove. A miscounted field gate moves the rise of `rd_enabled` by whole bursts, and this is checked on every cycle.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } fbs_state_e;
endpackage

// File: rtl/fbs_arbiter.sv
module fbs_arbiter (
    input  logic wr_ok,
    input  logic rd_ok,
    input  logic prev_was_rd,
    output logic grant_wr,
    output logic grant_rd
);
    // Contested: favour the direction not served last.
    always_comb begin
        grant_wr = wr_ok && (!rd_ok || prev_was_rd);
        grant_rd = rd_ok && (!wr_ok || !prev_was_rd);
    end
endmodule

// File: rtl/fbs_burst_ptr.sv
module fbs_burst_ptr #(
    parameter int FRAME_BURSTS = 32,
    localparam int PTR_W = (FRAME_BURSTS > 1) ? $clog2(FRAME_BURSTS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [PTR_W-1:0] ptr
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(FRAME_BURSTS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr <= '0;
        else if (advance)
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
endmodule

// File: rtl/fbs_field_gate.sv
module fbs_field_gate #(
    parameter int FIELD_BURSTS = 16,
    localparam int CNT_W = $clog2(FIELD_BURSTS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_done,
    output logic open
);
    logic [CNT_W-1:0] stored;
    localparam logic [CNT_W-1:0] TARGET = CNT_W'(FIELD_BURSTS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stored <= '0;
            open   <= 1'b0;
        end else if (wr_done && !open) begin
            stored <= stored + 1'b1;
            if (stored + 1'b1 == TARGET)
                open <= 1'b1;
        end
    end
endmodule

// File: rtl/fb_burst_sched.sv
module fb_burst_sched
    import fbs_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int BURST_LEN    = 4,
    parameter int BURST_CYC    = 8,
    parameter int FRAME_BURSTS = 32,
    parameter int FIELD_BURSTS = 16,
    parameter int LVL_W        = 8,
    parameter int ADDR_W       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  wf_level,
    input  logic [DATA_W-1:0] wf_data,
    output logic              wf_pop,
    input  logic [LVL_W-1:0]  rf_free,
    output logic              rf_push,
    output logic [DATA_W-1:0] rf_data,
    output logic              mem_cmd,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_wvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_rvalid,
    output logic              rd_enabled
);
    localparam int PTR_W  = (FRAME_BURSTS > 1) ? $clog2(FRAME_BURSTS) : 1;
    localparam int BEAT_W = $clog2(BURST_CYC);
    localparam int OFS_W  = $clog2(BURST_LEN);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_CYC - 1);
    localparam logic [LVL_W-1:0]  NEED      = LVL_W'(BURST_LEN);

    fbs_state_e        state, state_nx;
    logic [BEAT_W-1:0] beat;
    logic              prev_was_rd;
    logic              last_beat;
    logic              wr_ok, rd_ok, grant_wr, grant_rd;
    logic [1:0]        ptr_adv;
    logic [PTR_W-1:0]  ptr [2];

    assign last_beat = (beat == LAST_BEAT);
    assign wr_ok     = (wf_level >= NEED);
    assign rd_ok     = rd_enabled && (rf_free >= NEED);

    fbs_arbiter u_arb (
        .wr_ok       (wr_ok),
        .rd_ok       (rd_ok),
        .prev_was_rd (prev_was_rd),
        .grant_wr    (grant_wr),
        .grant_rd    (grant_rd)
    );

    // Index 0: write pointer, index 1: read pointer.
    assign ptr_adv[0] = (state == ST_WRITE) && last_beat;
    assign ptr_adv[1] = (state == ST_READ)  && last_beat;

    for (genvar g = 0; g < 2; g++) begin : g_ptr
        fbs_burst_ptr #(.FRAME_BURSTS(FRAME_BURSTS)) u_ptr (
            .clk     (clk),
            .rst_n   (rst_n),
            .advance (ptr_adv[g]),
            .ptr     (ptr[g])
        );
    end

    fbs_field_gate #(.FIELD_BURSTS(FIELD_BURSTS)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_done (ptr_adv[0]),
        .open    (rd_enabled)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (grant_wr)      state_nx = ST_WRITE;
                else if (grant_rd) state_nx = ST_READ;
            end
            ST_WRITE, ST_READ: begin
                if (last_beat) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            beat        <= '0;
            prev_was_rd <= 1'b1;
        end else begin
            state <= state_nx;
            beat  <= (state == ST_IDLE) ? '0 : beat + 1'b1;
            if (state == ST_IDLE && grant_wr)
                prev_was_rd <= 1'b0;
            else if (state == ST_IDLE && grant_rd)
                prev_was_rd <= 1'b1;
        end
    end

    always_comb begin
        mem_cmd    = (state != ST_IDLE) && (beat == '0);
        mem_we     = (state == ST_WRITE);
        mem_addr   = ADDR_W'({((state == ST_READ) ? ptr[1] : ptr[0]), {OFS_W{1'b0}}});
        wf_pop     = (state == ST_WRITE) && ({1'b0, beat} < (BEAT_W + 1)'(BURST_LEN));
        mem_wvalid = wf_pop;
        mem_wdata  = wf_data;
        rf_push    = (state == ST_READ) && mem_rvalid;
        rf_data    = mem_rdata;
    end
endmodule

// File: rtl/fbs_checker.sv
module fbs_checker #(
    parameter int BURST_LEN = 4,
    parameter int LVL_W     = 8,
    parameter int ADDR_W    = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LVL_W-1:0]  wf_level,
    input logic [LVL_W-1:0]  rf_free,
    input logic              wf_pop,
    input logic              rf_push,
    input logic              mem_cmd,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              rd_enabled
);
    AST_WR_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd && mem_we) |-> ($past(wf_level) >= LVL_W'(BURST_LEN)));  // R2
    AST_RD_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd && !mem_we) |-> (($past(rf_free) >= LVL_W'(BURST_LEN)) && $past(rd_enabled)));  // R3
    AST_GATE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_enabled |=> rd_enabled);  // R5
    AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cmd |=> !mem_cmd);  // R1
    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cmd |-> ((mem_addr % ADDR_W'(BURST_LEN)) == '0));  // R7
    AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(wf_pop && rf_push));  // R8
endmodule

bind fb_burst_sched fbs_checker #(
    .BURST_LEN (BURST_LEN),
    .LVL_W     (LVL_W),
    .ADDR_W    (ADDR_W)
) u_fbs_checker (.*);

// File: tb/tb_fb_burst_sched.sv
module tb_fb_burst_sched;
    localparam int DW = 32, BL = 4, BC = 8, FRAME = 32, FIELD = 16, LW = 8, AW = 16;
    localparam int MEMW = FRAME * BL;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [LW-1:0] wf_level = '0, rf_free = '0;
    logic [DW-1:0] wf_data = '0, mem_rdata = '0;
    logic mem_rvalid = 1'b0;
    logic wf_pop, rf_push, mem_cmd, mem_we, mem_wvalid, rd_enabled;
    logic [DW-1:0] rf_data, mem_wdata;
    logic [AW-1:0] mem_addr;

    always #2 clk = ~clk;

    fb_burst_sched #(.DATA_W(DW), .BURST_LEN(BL), .BURST_CYC(BC), .FRAME_BURSTS(FRAME),
                     .FIELD_BURSTS(FIELD), .LVL_W(LW), .ADDR_W(AW)) dut (.*);

    int checks = 0, errors = 0;
    logic [DW-1:0] mem_m [MEMW];
    int active = 0, beat_m = 0, dir_rd = 0, cur_addr = 0;
    int wr_n = 0, rd_n = 0, wr_done = 0, gate_m = 0, last_rd = 1;
    int pred_valid = 0, pred = 0;  // pred: 0 none, 1 write, 2 read
    logic [DW-1:0] wf_cnt = 32'h1000_0000;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int predict(input int lvl, input int fr, input int gate, input int lr);
        bit w, r;
        w = lvl >= BL;
        r = (gate != 0) && (fr >= BL);
        if (w && r) return lr ? 1 : 2;
        if (w) return 1;
        if (r) return 2;
        return 0;
    endfunction

    task automatic step(input int lvl, input int fr);
        @(negedge clk);
        // model advance
        if (active != 0) begin
            beat_m++;
            if (beat_m == BC) begin
                active = 0;
                if (dir_rd == 0) begin
                    wr_done++;
                    if (wr_done >= FIELD) gate_m = 1;
                end
            end
        end
        // decision prediction from previous idle cycle
        if (pred_valid != 0) begin
            chk(mem_cmd == (pred != 0), (pred == 2) ? "R3/R6 cmd" : "R2/R6 cmd", int'(mem_cmd), int'(pred != 0));
            if (mem_cmd && pred != 0)
                chk(mem_we == (pred == 1), "R6 direction", int'(mem_we), int'(pred == 1));
        end
        if (mem_cmd) begin
            chk(active == 0, "R1 spacing", active, 0);
            active = 1; beat_m = 0; dir_rd = mem_we ? 0 : 1;
            last_rd = dir_rd;
            cur_addr = int'(mem_addr);
            if (dir_rd == 0) begin
                chk(cur_addr == (wr_n % FRAME) * BL, "R7 write addr", cur_addr, (wr_n % FRAME) * BL);
                wr_n++;
            end else begin
                chk(cur_addr == (rd_n % FRAME) * BL, "R7 read addr", cur_addr, (rd_n % FRAME) * BL);
                rd_n++;
            end
        end
        if (active != 0 && dir_rd == 0) begin
            chk(wf_pop == (beat_m < BL), "R1 pop pattern", int'(wf_pop), int'(beat_m < BL));
            chk(mem_wvalid == wf_pop, "R1 wvalid", int'(mem_wvalid), int'(wf_pop));
            if (wf_pop) begin
                chk(mem_wdata == wf_cnt, "R8 write data", int'(mem_wdata), int'(wf_cnt));
                mem_m[(cur_addr + beat_m) % MEMW] = mem_wdata;
                wf_cnt++;
            end
        end else begin
            chk(!wf_pop, "R1 no pop outside write", int'(wf_pop), 0);
        end
        if (active != 0 && dir_rd == 1) begin
            chk(rf_push == (beat_m >= 1 && beat_m <= BL), "R8 push", int'(rf_push), int'(beat_m >= 1 && beat_m <= BL));
            if (rf_push)
                chk(rf_data == mem_m[(cur_addr + beat_m - 1) % MEMW], "R8 read data",
                    int'(rf_data), int'(mem_m[(cur_addr + beat_m - 1) % MEMW]));
        end else begin
            chk(!rf_push, "R8 no push outside read", int'(rf_push), 0);
        end
        chk(rd_enabled == gate_m[0], "R4/R5 gate", int'(rd_enabled), gate_m);
        // drive
        wf_level = LW'(lvl);
        rf_free  = LW'(fr);
        wf_data  = wf_cnt;
        if (active != 0 && dir_rd == 1 && beat_m < BL) begin
            mem_rvalid = 1'b1;
            mem_rdata  = mem_m[(cur_addr + beat_m) % MEMW];
        end else begin
            mem_rvalid = 1'b0;
            mem_rdata  = $urandom();
        end
        pred_valid = (active == 0);
        pred = predict(lvl, fr, gate_m, last_rd);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < MEMW; i++) mem_m[i] = '0;
        repeat (3) @(negedge clk);
        chk(!mem_cmd && !wf_pop && !rf_push && !rd_enabled, "R9 in reset",
            int'({mem_cmd, wf_pop, rf_push, rd_enabled}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_cmd && !rd_enabled, "R9 after reset", int'({mem_cmd, rd_enabled}), 0);
        pred_valid = 1; pred = 0;
        // directed: boundary levels just below the threshold keep the block idle
        for (int i = 0; i < 20; i++) step(3, 8);
        // directed: exactly at threshold, read space present but gate closed
        for (int i = 0; i < 200; i++) step(4, 8);
        // directed: both eligible continuously, alternation
        for (int i = 0; i < 300; i++) step(8, 8);
        // directed: read space one short of a burst
        for (int i = 0; i < 60; i++) step(8, 3);
        // directed: only reads eligible
        for (int i = 0; i < 60; i++) step(0, 4);
        // constrained random
        for (int i = 0; i < 4000; i++)
            step(int'($urandom_range(0, 8)), int'($urandom_range(0, 8)));
        chk(wr_n > FRAME, "R7 write wrap exercised", wr_n, FRAME + 1);
        chk(rd_n > FRAME, "R7 read wrap exercised", rd_n, FRAME + 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule